// File: doc/BRIEF.md
# Zero-Operand Stack Processor

This block executes a three-instruction stack program one instruction at a time. An outside sequencer presents an opcode and a 16-bit argument together with a valid strobe. A push instruction places the argument on a small hardware operand stack. An add instruction names no operands: it takes the two topmost entries and leaves their sum in their place. A pop instruction takes the top entry off the stack and writes it to the data-memory address carried in the low bits of the argument.

The stack depth, the current top value and two sticky error flags are always visible at the ports. An instruction that would overfill or overdrain the stack sets its flag and leaves the stack exactly as it was. As an example, the program push 1, push 2, add, pop to address A leaves the stack empty and writes 3 to address A.

Top module: `stk_engine`

## Requirements
- R1: When `instr_vld` is high, `instr_op` is 2'b01 (push) and the stack holds fewer than 8 entries, then after that clock edge `stk_depth` has risen by one and `stk_tos` equals `instr_arg`. The entries already on the stack keep their order beneath it.
- R2: A valid add (`instr_op` = 2'b10) with at least two entries removes the top two entries and pushes their sum, so `stk_depth` falls by one. Pushing 1 and then 2, then adding, leaves 3 on top.
- R3: A valid pop (`instr_op` = 2'b11) on a non-empty stack lowers `stk_depth` by one. For the single cycle after its edge it drives `mem_we` high, with `mem_addr` equal to `instr_arg[7:0]` and `mem_wdata` equal to the old top value.
- R4: The stack holds at most 8 entries of 16 bits. `stk_depth` counts from 0 to 8, and `stk_tos` reads 0 while the stack is empty.
- R5: A valid push on a full stack sets `ovf_flag` and changes neither the depth nor any entry. The flag stays set until reset.
- R6: A valid add with fewer than two entries, or a valid pop on an empty stack, sets `udf_flag`, changes neither the depth nor any entry, and produces no memory write. The flag stays set until reset.
- R7: Each instruction takes effect at the clock edge that samples its valid strobe. A cycle with `instr_vld` low, or a valid instruction with opcode 2'b00, changes nothing.
- R8: While `rst` is high, the next edge empties the stack, clears both flags and drops `mem_we`.
- R9: The add result wraps modulo 2^16. For example, 0xFFFF plus 0x0002 gives 0x0001.
- R10: `mem_we` is high only in the cycle right after a valid pop on a non-empty stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_vld | input | 1 | Instruction strobe |
| instr_op | input | 2 | 00 none, 01 push, 10 add, 11 pop |
| instr_arg | input | 16 | Push immediate, or pop target address in its low 8 bits |
| mem_we | output | 1 | Data-memory write strobe |
| mem_addr | output | 8 | Data-memory write address |
| mem_wdata | output | 16 | Data-memory write value |
| stk_depth | output | 4 | Number of entries on the stack |
| stk_tos | output | 16 | Top entry, 0 when empty |
| ovf_flag | output | 1 | Sticky overflow indication |
| udf_flag | output | 1 | Sticky underflow indication |

## Verification
The assertions assume that `instr_vld`, `instr_op` and `instr_arg` are stable and known at every sampling edge. They also assume that `rst` is high at the first edge, since the reset check looks only one cycle ahead. The bench changes its inputs on the falling edge only and holds the strobe low throughout reset. It then walks every opcode, strobed and unstrobed, from every depth from empty to full, so that each boundary of depth meets each instruction.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_ADD  = 2'b10,
        OP_POP  = 2'b11
    } stk_op_e;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             vld,
    input  stk_op_e          op,
    input  logic [CNT_W-1:0] depth,
    output logic             do_push,
    output logic             do_add,
    output logic             do_pop,
    output logic             err_ovf,
    output logic             err_udf
);

    logic is_full;
    logic is_empty;
    logic has_pair;

    always_comb begin
        is_full  = (depth == CNT_W'(DEPTH));
        is_empty = (depth == '0);
        has_pair = (depth >= CNT_W'(2));

        do_push = vld && (op == OP_PUSH) && !is_full;
        do_add  = vld && (op == OP_ADD)  && has_pair;
        do_pop  = vld && (op == OP_POP)  && !is_empty;

        err_ovf = vld && (op == OP_PUSH) && is_full;
        err_udf = vld && (((op == OP_ADD) && !has_pair) ||
                          ((op == OP_POP) && is_empty));
    end

endmodule

// File: rtl/stk_adder.sv
module stk_adder #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] sum
);

    always_comb begin
        sum = opnd_a + opnd_b;
    end

endmodule

// File: rtl/stk_file.sv
module stk_file #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b
);

    logic [DATA_W-1:0] ent_d [DEPTH];
    logic [DATA_W-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
            end
        end
    end

    always_comb begin
        rd_a = ent_q[rd_idx_a];
        rd_b = ent_q[rd_idx_b];
    end

endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         instr_vld,
    input  logic [1:0]                   instr_op,
    input  logic [DATA_W-1:0]            instr_arg,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    output logic [$clog2(DEPTH+1)-1:0]   stk_depth,
    output logic [DATA_W-1:0]            stk_tos,
    output logic                         ovf_flag,
    output logic                         udf_flag
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0]  depth;
        logic              ovf;
        logic              udf;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic              do_push;
    logic              do_add;
    logic              do_pop;
    logic              err_ovf;
    logic              err_udf;
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  sec_idx;
    logic [IDX_W-1:0]  new_idx;
    logic [DATA_W-1:0] top_val;
    logic [DATA_W-1:0] sec_val;
    logic [DATA_W-1:0] sum_val;
    logic              f_wr_en;
    logic [IDX_W-1:0]  f_wr_idx;
    logic [DATA_W-1:0] f_wr_data;

    stk_decode #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) decode_i (
        .vld     (instr_vld),
        .op      (stk_op_e'(instr_op)),
        .depth   (ctl_q.depth),
        .do_push (do_push),
        .do_add  (do_add),
        .do_pop  (do_pop),
        .err_ovf (err_ovf),
        .err_udf (err_udf)
    );

    stk_adder #(
        .DATA_W (DATA_W)
    ) adder_i (
        .opnd_a (top_val),
        .opnd_b (sec_val),
        .sum    (sum_val)
    );

    stk_file #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) file_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (f_wr_en),
        .wr_idx   (f_wr_idx),
        .wr_data  (f_wr_data),
        .rd_idx_a (top_idx),
        .rd_idx_b (sec_idx),
        .rd_a     (top_val),
        .rd_b     (sec_val)
    );

    always_comb begin
        top_idx = IDX_W'(ctl_q.depth - CNT_W'(1));
        sec_idx = IDX_W'(ctl_q.depth - CNT_W'(2));
        new_idx = IDX_W'(ctl_q.depth);

        f_wr_en   = do_push || do_add;
        f_wr_idx  = do_push ? new_idx : sec_idx;
        f_wr_data = do_push ? instr_arg : sum_val;

        ctl_d       = ctl_q;
        ctl_d.we    = 1'b0;
        ctl_d.ovf   = ctl_q.ovf || err_ovf;
        ctl_d.udf   = ctl_q.udf || err_udf;

        if (do_push) begin
            ctl_d.depth = ctl_q.depth + CNT_W'(1);
        end else if (do_add) begin
            ctl_d.depth = ctl_q.depth - CNT_W'(1);
        end else if (do_pop) begin
            ctl_d.depth = ctl_q.depth - CNT_W'(1);
            ctl_d.we    = 1'b1;
            ctl_d.waddr = instr_arg[ADDR_W-1:0];
            ctl_d.wdata = top_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        mem_we    = ctl_q.we;
        mem_addr  = ctl_q.waddr;
        mem_wdata = ctl_q.wdata;
        stk_depth = ctl_q.depth;
        stk_tos   = (ctl_q.depth == '0) ? '0 : top_val;
        ovf_flag  = ctl_q.ovf;
        udf_flag  = ctl_q.udf;
    end

endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       instr_vld,
    input logic [1:0]                 instr_op,
    input logic [DATA_W-1:0]          instr_arg,
    input logic                       mem_we,
    input logic [ADDR_W-1:0]          mem_addr,
    input logic [DATA_W-1:0]          mem_wdata,
    input logic [$clog2(DEPTH+1)-1:0] stk_depth,
    input logic [DATA_W-1:0]          stk_tos,
    input logic                       ovf_flag,
    input logic                       udf_flag
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic push_ok, push_full, add_ok, pop_ok, bad_drain;

    always_comb begin
        push_ok   = instr_vld && (instr_op == 2'b01) && (stk_depth <  CNT_W'(DEPTH));
        push_full = instr_vld && (instr_op == 2'b01) && (stk_depth == CNT_W'(DEPTH));
        add_ok    = instr_vld && (instr_op == 2'b10) && (stk_depth >= CNT_W'(2));
        pop_ok    = instr_vld && (instr_op == 2'b11) && (stk_depth != '0);
        bad_drain = instr_vld && (((instr_op == 2'b10) && (stk_depth < CNT_W'(2))) ||
                                  ((instr_op == 2'b11) && (stk_depth == '0)));
    end

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (stk_depth == '0) && !ovf_flag && !udf_flag && !mem_we);

    assert_depth_bound_R4: assert property (@(posedge clk) disable iff (rst)
        stk_depth <= CNT_W'(DEPTH));

    assert_empty_tos_R4: assert property (@(posedge clk) disable iff (rst)
        (stk_depth == '0) |-> (stk_tos == '0));

    assert_push_top_R1: assert property (@(posedge clk) disable iff (rst)
        push_ok |=> (stk_depth == $past(stk_depth) + CNT_W'(1)) && (stk_tos == $past(instr_arg)));

    assert_add_depth_R2: assert property (@(posedge clk) disable iff (rst)
        add_ok |=> (stk_depth == $past(stk_depth) - CNT_W'(1)));

    assert_pop_write_R3: assert property (@(posedge clk) disable iff (rst)
        pop_ok |=> mem_we && (mem_addr == $past(instr_arg[ADDR_W-1:0])) &&
                   (mem_wdata == $past(stk_tos)) &&
                   (stk_depth == $past(stk_depth) - CNT_W'(1)));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        push_full |=> ovf_flag && (stk_depth == $past(stk_depth)) && (stk_tos == $past(stk_tos)));

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        bad_drain |=> udf_flag && (stk_depth == $past(stk_depth)) && !mem_we);

    assert_udf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        udf_flag |=> udf_flag);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!instr_vld || (instr_op == 2'b00)) |=> $stable(stk_depth) && $stable(stk_tos) && !mem_we);

    assert_we_cause_R10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(pop_ok));

endmodule

bind stk_engine stk_engine_chk #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .instr_vld (instr_vld),
    .instr_op  (instr_op),
    .instr_arg (instr_arg),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .stk_depth (stk_depth),
    .stk_tos   (stk_tos),
    .ovf_flag  (ovf_flag),
    .udf_flag  (udf_flag)
);

// File: tb/stk_engine_tb_top.sv
module stk_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_vld = 1'b0;
    logic [1:0]  instr_op = 2'b00;
    logic [15:0] instr_arg = '0;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [3:0]  stk_depth;
    logic [15:0] stk_tos;
    logic        ovf_flag;
    logic        udf_flag;

    int n_tot = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] m_stk [8];
    int          m_d;
    logic        m_ovf, m_udf, e_we;
    logic [7:0]  e_addr;
    logic [15:0] e_data;

    always #4 clk = ~clk;

    stk_engine dut_i (
        .clk       (clk),
        .rst       (rst),
        .instr_vld (instr_vld),
        .instr_op  (instr_op),
        .instr_arg (instr_arg),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .stk_depth (stk_depth),
        .stk_tos   (stk_tos),
        .ovf_flag  (ovf_flag),
        .udf_flag  (udf_flag)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [15:0] e_tos;
        e_tos = (m_d == 0) ? 16'h0 : m_stk[m_d-1];
        chk(tag, "depth", 32'(stk_depth), 32'(m_d));
        chk(tag, "tos", 32'(stk_tos), 32'(e_tos));
        chk(tag, "ovf", 32'(ovf_flag), 32'(m_ovf));
        chk(tag, "udf", 32'(udf_flag), 32'(m_udf));
        chk(tag, "we", 32'(mem_we), 32'(e_we));
        if (e_we) begin
            chk(tag, "addr", 32'(mem_addr), 32'(e_addr));
            chk(tag, "wdata", 32'(mem_wdata), 32'(e_data));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        instr_vld = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_d = 0; m_ovf = 1'b0; m_udf = 1'b0; e_we = 1'b0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
    endtask

    task automatic model(logic [1:0] op, logic [15:0] arg);
        e_we = 1'b0;
        case (op)
            2'b01: if (m_d == 8) m_ovf = 1'b1;
                   else begin m_stk[m_d] = arg; m_d++; end
            2'b10: if (m_d < 2) m_udf = 1'b1;
                   else begin m_stk[m_d-2] = m_stk[m_d-2] + m_stk[m_d-1]; m_d--; end
            2'b11: if (m_d == 0) m_udf = 1'b1;
                   else begin e_we = 1'b1; e_addr = arg[7:0]; e_data = m_stk[m_d-1]; m_d--; end
            default: ;
        endcase
    endtask

    task automatic op_run(string tag, logic [1:0] op, logic [15:0] arg, bit vld = 1'b1);
        instr_vld = vld;
        instr_op  = op;
        instr_arg = arg;
        @(posedge clk);
        @(negedge clk);
        instr_vld = 1'b0;
        instr_op  = 2'b00;
        if (vld) model(op, arg);
        else e_we = 1'b0;
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tot++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        check_all("R8 reset state");

        op_run("R1 push 1", 2'b01, 16'd1);
        op_run("R1 push 2", 2'b01, 16'd2);
        op_run("R2 add 2+1", 2'b10, 16'd0);
        chk("R2 sum three", "tos", 32'(stk_tos), 32'd3);
        op_run("R3 pop to 2a", 2'b11, 16'h002A);
        chk("R3 pop value", "wdata", 32'(mem_wdata), 32'd3);
        op_run("R10 we drops", 2'b00, 16'h0, 1'b0);
        op_run("R6 pop empty", 2'b11, 16'h0011);
        op_run("R6 udf sticky after push", 2'b01, 16'h0055);

        for (int d = 0; d <= 8; d++) begin
            for (int op = 0; op < 4; op++) begin
                for (int v = 0; v < 2; v++) begin
                    do_reset();
                    for (int k = 0; k < d; k++)
                        op_run("R4 fill", 2'b01, 16'(d * 4099 + k * 517 + 1));
                    if (v == 0)
                        op_run("R7 unstrobed", 2'(op), 16'h00C3 + 16'(d), 1'b0);
                    else if (op == 1)
                        op_run(d == 8 ? "R5 push full" : "R1 push sweep", 2'b01, 16'hA000 + 16'(d));
                    else if (op == 2)
                        op_run(d < 2 ? "R6 add short" : "R2 add sweep", 2'b10, 16'h0);
                    else if (op == 3)
                        op_run(d == 0 ? "R6 pop empty sweep" : "R3 pop sweep", 2'b11, 16'hFF00 + 16'(d * 3));
                    else
                        op_run("R7 opcode none", 2'b00, 16'h1234);
                    op_run("R10 idle after", 2'b00, 16'h0, 1'b0);
                end
            end
        end

        do_reset();
        op_run("R9 push ffff", 2'b01, 16'hFFFF);
        op_run("R9 push 2", 2'b01, 16'h0002);
        op_run("R9 wrap add", 2'b10, 16'h0);
        chk("R9 wrap value", "tos", 32'(stk_tos), 32'h0001);
        op_run("R9 push 8000", 2'b01, 16'h8000);
        op_run("R9 push 8000b", 2'b01, 16'h8000);
        op_run("R9 wrap zero", 2'b10, 16'h0);

        do_reset();
        for (int k = 0; k < 9; k++) op_run("R5 fill over", 2'b01, 16'(k * 11 + 7));
        for (int k = 0; k < 8; k++) op_run("R5 ovf sticky pops", 2'b11, 16'(k));
        op_run("R2 add empty", 2'b10, 16'h0);
        for (int k = 0; k < 5; k++) op_run("R4 refill", 2'b01, 16'(k + 100));
        for (int k = 0; k < 4; k++) op_run("R2 chain add", 2'b10, 16'h0);
        op_run("R3 pop chain", 2'b11, 16'h00EE);

        do_reset();
        check_all("R8 reset after errors");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule